// File: doc/BRIEF.md
# Stack-Aware Operand Address Generator

This unit turns one encoded operand field of a 16-bit word-addressed processor into something the execute stage can act on at once: a register reference, a memory address, or a ready value. It is told whether the operand sits in the source slot or the destination slot. It sees the current stack pointer, the general registers, the word that follows the instruction, and a pointer to the next unread instruction word. From these it returns the resolved operand, the updated stack pointer, whether the following word was used, the extra cycles charged, and whether a write back must be dropped.

One stack code changes meaning with the slot. In the destination slot it pushes: the stack pointer is decremented first and the write goes to the new top. In the source slot it pops: the read comes from the current top and the stack pointer is then incremented. Modes that take the following word charge one extra cycle and advance the word pointer. An instruction resolves its source first and its destination second, chaining the word pointer from one to the other, so two such operands take their words in that order. A literal named as a destination turns into a value with the write suppressed. The operand still takes its normal cycles.

Each request is registered. The result appears one clock after `req_valid`.

Top module: `oag_top`

## Requirements
- R1: Codes 0x00-0x07 give a register reference (`res_kind`=0) with `res_ref` equal to the code. They use no following word and charge 0 extra cycles.
- R2: Codes 0x08-0x0F give a memory operand (`res_kind`=1) at the value of general register code[2:0]. They use no following word and charge 0 extra cycles.
- R3: Codes 0x10-0x17 give a memory operand at general register code[2:0] plus `next_word`, wrapping modulo 2^16. They use the following word and charge 1 extra cycle.
- R4: Code 0x18 in the destination slot (`is_dst`=1) gives a memory operand at `sp_in`-1 and returns `sp_out`=`sp_in`-1.
- R5: Code 0x18 in the source slot gives a memory operand at `sp_in` and returns `sp_out`=`sp_in`+1.
- R6: Code 0x19 gives a memory operand at `sp_in` in either slot. The stack pointer is unchanged. Every code other than 0x18 leaves `sp_out`=`sp_in`.
- R7: Code 0x1A gives a memory operand at `sp_in`+`next_word`, wrapping. It uses the following word and charges 1 extra cycle.
- R8: Code 0x1E gives a memory operand at `next_word`. Code 0x1F gives a value (`res_kind`=2) equal to `next_word`. Both use the following word and charge 1 extra cycle.
- R9: Codes 0x20-0x3F give a value equal to code minus 0x21, modulo 2^16 (0x20 gives 0xFFFF). They use no following word and charge 0 extra cycles.
- R10: `res_wr_suppress` is 1 exactly when a value operand (code 0x1F or 0x20-0x3F) is in the destination slot. Its extra cycle count is the same as in the source slot.
- R11: Codes 0x1B, 0x1C and 0x1D give register references 8 (stack pointer), 9 (program counter) and 10 (extra/overflow register). They charge 0 extra cycles.
- R12: `ptr_out` equals `ptr_in` plus 1 when the following word is used, and `ptr_in` otherwise. Feeding the source's `ptr_out` into the destination request makes the source take its word first.
- R13: While reset is held, every output is 0. `res_valid` is high exactly one clock after `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Resolve the operand presented this cycle |
| is_dst | input | 1 | 1 = destination slot, 0 = source slot |
| op_code | input | 6 | Operand field encoding |
| next_word | input | 16 | Instruction word at `ptr_in` |
| ptr_in | input | 16 | Address of the next unread instruction word |
| sp_in | input | 16 | Current stack pointer |
| gp_regs | input | 128 | Eight general registers, register k at bits [16k+15:16k] |
| res_valid | output | 1 | Result valid |
| res_kind | output | 2 | 0 register, 1 memory, 2 value |
| res_ref | output | 4 | Register reference when kind is 0 |
| res_data | output | 16 | Memory address or value |
| res_used_next | output | 1 | Following word was used |
| res_cycles | output | 2 | Extra cycles charged |
| sp_out | output | 16 | Updated stack pointer |
| res_wr_suppress | output | 1 | Write back must be dropped |
| ptr_out | output | 16 | Word pointer after this operand |

## Verification
On every cycle, the assertions check the one-cycle response timing and that the word pointer moves by exactly the used-word flag. They also check that only the stack code moves the stack pointer, by one step in the direction the slot dictates, and that write suppression only ever marks value operands in the destination slot. The bench scenarios are needed for the actual address arithmetic: wrap of offset and pick sums, the short-literal value table at both ends, and peek reading and writing the same word. The scenarios also cover source-then-destination word ordering across two chained requests, and the mapping of the special registers.

// File: rtl/oag_pkg.sv
package oag_pkg;
    localparam int CODE_W = 6;
    localparam int NREG   = 8;
    localparam int REF_W  = 4;

    typedef enum logic [3:0] {
        M_REG, M_IND, M_IND_OFF, M_STACK, M_PEEK, M_PICK,
        M_SPR, M_PCR, M_EXR, M_NIND, M_NLIT, M_SLIT
    } mode_e;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_MEM = 2'd1,
        K_VAL = 2'd2
    } kind_e;

    localparam logic [REF_W-1:0] REF_SP = 4'd8;
    localparam logic [REF_W-1:0] REF_PC = 4'd9;
    localparam logic [REF_W-1:0] REF_EX = 4'd10;
endpackage

// File: rtl/oag_decode.sv
module oag_decode
    import oag_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output mode_e             mode,
    output logic [2:0]        reg_idx
);
    always_comb begin
        reg_idx = code[2:0];
        if (code[5]) begin
            mode = M_SLIT;
        end else begin
            unique case (code[4:3])
                2'b00: mode = M_REG;
                2'b01: mode = M_IND;
                2'b10: mode = M_IND_OFF;
                default: begin
                    unique case (code[2:0])
                        3'd0: mode = M_STACK;
                        3'd1: mode = M_PEEK;
                        3'd2: mode = M_PICK;
                        3'd3: mode = M_SPR;
                        3'd4: mode = M_PCR;
                        3'd5: mode = M_EXR;
                        3'd6: mode = M_NIND;
                        default: mode = M_NLIT;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/oag_calc.sv
module oag_calc
    import oag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mode_e                  mode,
    input  logic [CODE_W-1:0]      code,
    input  logic [2:0]             reg_idx,
    input  logic                   is_dst,
    input  logic [DATA_W-1:0]      next_word,
    input  logic [DATA_W-1:0]      sp_in,
    input  logic [NREG*DATA_W-1:0] gp_regs,
    output kind_e                  kind,
    output logic [REF_W-1:0]       ref_idx,
    output logic [DATA_W-1:0]      data,
    output logic                   used_next,
    output logic [DATA_W-1:0]      sp_new,
    output logic                   wr_suppress
);
    localparam logic [DATA_W-1:0] SLIT_BIAS = DATA_W'(33);

    logic [DATA_W-1:0] regs_a [NREG];
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign regs_a[g] = gp_regs[g*DATA_W +: DATA_W];
    end

    logic [DATA_W-1:0] rval;
    assign rval = regs_a[reg_idx];

    always_comb begin
        kind        = K_MEM;
        ref_idx     = '0;
        data        = '0;
        used_next   = 1'b0;
        sp_new      = sp_in;
        wr_suppress = 1'b0;
        unique case (mode)
            M_REG: begin
                kind    = K_REG;
                ref_idx = {1'b0, reg_idx};
            end
            M_IND:     data = rval;
            M_IND_OFF: begin
                data      = rval + next_word;
                used_next = 1'b1;
            end
            M_STACK: begin
                if (is_dst) begin
                    sp_new = sp_in - 1'b1;
                    data   = sp_in - 1'b1;
                end else begin
                    sp_new = sp_in + 1'b1;
                    data   = sp_in;
                end
            end
            M_PEEK: data = sp_in;
            M_PICK: begin
                data      = sp_in + next_word;
                used_next = 1'b1;
            end
            M_SPR: begin kind = K_REG; ref_idx = REF_SP; end
            M_PCR: begin kind = K_REG; ref_idx = REF_PC; end
            M_EXR: begin kind = K_REG; ref_idx = REF_EX; end
            M_NIND: begin
                data      = next_word;
                used_next = 1'b1;
            end
            M_NLIT: begin
                kind        = K_VAL;
                data        = next_word;
                used_next   = 1'b1;
                wr_suppress = is_dst;
            end
            default: begin
                kind        = K_VAL;
                data        = DATA_W'(code) - SLIT_BIAS;
                wr_suppress = is_dst;
            end
        endcase
    end
endmodule

// File: rtl/oag_top.sv
module oag_top
    import oag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   is_dst,
    input  logic [CODE_W-1:0]      op_code,
    input  logic [DATA_W-1:0]      next_word,
    input  logic [DATA_W-1:0]      ptr_in,
    input  logic [DATA_W-1:0]      sp_in,
    input  logic [NREG*DATA_W-1:0] gp_regs,
    output logic                   res_valid,
    output logic [1:0]             res_kind,
    output logic [REF_W-1:0]       res_ref,
    output logic [DATA_W-1:0]      res_data,
    output logic                   res_used_next,
    output logic [1:0]             res_cycles,
    output logic [DATA_W-1:0]      sp_out,
    output logic                   res_wr_suppress,
    output logic [DATA_W-1:0]      ptr_out
);
    typedef struct packed {
        logic              valid;
        logic [1:0]        kind;
        logic [REF_W-1:0]  ref_idx;
        logic [DATA_W-1:0] data;
        logic              used;
        logic [1:0]        cycles;
        logic [DATA_W-1:0] sp;
        logic              supp;
        logic [DATA_W-1:0] ptr;
    } res_t;

    mode_e             mode;
    logic [2:0]        reg_idx;
    kind_e             c_kind;
    logic [REF_W-1:0]  c_ref;
    logic [DATA_W-1:0] c_data;
    logic              c_used;
    logic [DATA_W-1:0] c_sp;
    logic              c_supp;
    res_t              res_d, res_q;

    oag_decode u_dec (
        .code    (op_code),
        .mode    (mode),
        .reg_idx (reg_idx)
    );

    oag_calc #(.DATA_W(DATA_W)) u_calc (
        .mode        (mode),
        .code        (op_code),
        .reg_idx     (reg_idx),
        .is_dst      (is_dst),
        .next_word   (next_word),
        .sp_in       (sp_in),
        .gp_regs     (gp_regs),
        .kind        (c_kind),
        .ref_idx     (c_ref),
        .data        (c_data),
        .used_next   (c_used),
        .sp_new      (c_sp),
        .wr_suppress (c_supp)
    );

    always_comb begin
        res_d         = res_q;
        res_d.valid   = req_valid;
        if (req_valid) begin
            res_d.kind    = c_kind;
            res_d.ref_idx = c_ref;
            res_d.data    = c_data;
            res_d.used    = c_used;
            res_d.cycles  = {1'b0, c_used};
            res_d.sp      = c_sp;
            res_d.supp    = c_supp;
            res_d.ptr     = ptr_in + DATA_W'(c_used);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid       = res_q.valid;
    assign res_kind        = res_q.kind;
    assign res_ref         = res_q.ref_idx;
    assign res_data        = res_q.data;
    assign res_used_next   = res_q.used;
    assign res_cycles      = res_q.cycles;
    assign sp_out          = res_q.sp;
    assign res_wr_suppress = res_q.supp;
    assign ptr_out         = res_q.ptr;

    p_valid_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid && rst_n));

    p_ptr_advance_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ptr_out == $past(ptr_in) + DATA_W'(res_used_next));

    p_cycle_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_cycles == {1'b0, res_used_next});

    p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(is_dst && op_code == 6'h18)
        |-> sp_out == $past(sp_in) - 1'b1 && res_data == sp_out);

    p_pop_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(!is_dst && op_code == 6'h18)
        |-> sp_out == $past(sp_in) + 1'b1 && res_data == $past(sp_in));

    p_sp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(op_code != 6'h18) |-> sp_out == $past(sp_in));

    p_suppress_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_wr_suppress |-> res_kind == 2'd2 && $past(is_dst));
endmodule

// File: tb/sim_oag_top.sv
module sim_oag_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         is_dst = 1'b0;
    logic [5:0]   op_code = '0;
    logic [15:0]  next_word = '0;
    logic [15:0]  ptr_in = '0;
    logic [15:0]  sp_in = '0;
    logic [127:0] gp_regs = '0;
    logic         res_valid, res_used_next, res_wr_suppress;
    logic [1:0]   res_kind, res_cycles;
    logic [3:0]   res_ref;
    logic [15:0]  res_data, sp_out, ptr_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    oag_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic dst, input logic [5:0] code, input logic [15:0] nw,
                         input logic [15:0] ptr, input logic [15:0] sp);
        @(negedge clk);
        req_valid = 1'b1; is_dst = dst; op_code = code;
        next_word = nw; ptr_in = ptr; sp_in = sp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_regs();
        for (int k = 0; k < 8; k++) gp_regs[k*16 +: 16] = 16'h1000 + 16'(k * 16'h0111);
    endtask

    task automatic t_reset();
        chk("R13 valid in reset", res_valid, 0);
        chk("R13 data in reset", res_data, 0);
        chk("R13 sp in reset", sp_out, 0);
    endtask

    task automatic t_regs();
        for (int k = 0; k < 8; k++) begin
            issue(1'b0, 6'(k), 16'h5555, 16'h10, 16'h100);
            chk("R1 kind", res_kind, 0);
            chk("R1 ref", res_ref, k);
            chk("R1 cycles", res_cycles, 0);
        end
        issue(1'b1, 6'h1B, 0, 0, 16'h100); chk("R11 sp ref", res_ref, 8); chk("R11 kind", res_kind, 0);
        issue(1'b0, 6'h1C, 0, 0, 16'h100); chk("R11 pc ref", res_ref, 9); chk("R11 cyc", res_cycles, 0);
        issue(1'b0, 6'h1D, 0, 0, 16'h100); chk("R11 ex ref", res_ref, 10);
    endtask

    task automatic t_indirect();
        issue(1'b0, 6'h0B, 16'h7777, 16'h20, 16'h100);
        chk("R2 kind", res_kind, 1); chk("R2 addr", res_data, 16'h1333);
        chk("R2 used", res_used_next, 0); chk("R2 cycles", res_cycles, 0);
        issue(1'b1, 6'h17, 16'hF000, 16'h20, 16'h100);
        chk("R3 addr wrap", res_data, 16'h0777);
        chk("R3 used", res_used_next, 1); chk("R3 cycles", res_cycles, 1);
        chk("R12 ptr", ptr_out, 16'h21);
    endtask

    task automatic t_stack();
        issue(1'b1, 6'h18, 0, 0, 16'h0000);
        chk("R4 push sp wrap", sp_out, 16'hFFFF); chk("R4 push addr", res_data, 16'hFFFF);
        chk("R4 kind", res_kind, 1);
        issue(1'b0, 6'h18, 0, 0, 16'hFFFF);
        chk("R5 pop addr", res_data, 16'hFFFF); chk("R5 pop sp", sp_out, 16'h0000);
        issue(1'b0, 6'h19, 0, 0, 16'h0200);
        chk("R6 peek src addr", res_data, 16'h0200); chk("R6 peek src sp", sp_out, 16'h0200);
        issue(1'b1, 6'h19, 0, 0, 16'h0200);
        chk("R6 peek dst addr", res_data, 16'h0200); chk("R6 peek dst sp", sp_out, 16'h0200);
        issue(1'b0, 6'h1A, 16'hFFFE, 16'h5, 16'h0003);
        chk("R7 pick addr", res_data, 16'h0001); chk("R7 cycles", res_cycles, 1);
        chk("R7 sp", sp_out, 16'h0003); chk("R7 used", res_used_next, 1);
    endtask

    task automatic t_nextword();
        issue(1'b0, 6'h1E, 16'hA120, 16'h40, 16'h100);
        chk("R8 ind kind", res_kind, 1); chk("R8 ind addr", res_data, 16'hA120);
        chk("R8 cycles", res_cycles, 1);
        issue(1'b0, 6'h1F, 16'h0BEE, 16'h40, 16'h100);
        chk("R8 lit kind", res_kind, 2); chk("R8 lit val", res_data, 16'h0BEE);
        chk("R10 src no suppress", res_wr_suppress, 0);
        issue(1'b1, 6'h1F, 16'h0BEE, 16'h40, 16'h100);
        chk("R10 dst suppress", res_wr_suppress, 1); chk("R10 cycles kept", res_cycles, 1);
        issue(1'b1, 6'h0A, 16'h0, 16'h40, 16'h100);
        chk("R10 mem no suppress", res_wr_suppress, 0);
    endtask

    task automatic t_short();
        issue(1'b0, 6'h20, 16'h1234, 16'h50, 16'h100);
        chk("R9 low end", res_data, 16'hFFFF); chk("R9 kind", res_kind, 2);
        chk("R9 used", res_used_next, 0); chk("R9 ptr", ptr_out, 16'h50);
        issue(1'b0, 6'h21, 0, 0, 16'h100); chk("R9 zero", res_data, 16'h0000);
        issue(1'b0, 6'h3F, 0, 0, 16'h100); chk("R9 high end", res_data, 16'h001E);
        issue(1'b1, 6'h2A, 0, 0, 16'h100);
        chk("R10 short dst suppress", res_wr_suppress, 1); chk("R10 short cycles", res_cycles, 0);
    endtask

    task automatic t_order();
        logic [15:0] p;
        issue(1'b0, 6'h1F, 16'h0002, 16'h0001, 16'h100);
        chk("R12 src value", res_data, 16'h0002);
        p = ptr_out;
        chk("R12 src ptr", p, 16'h0002);
        issue(1'b1, 6'h1E, 16'h0001, p, 16'h100);
        chk("R12 dst ptr", ptr_out, 16'h0003);
        chk("R12 dst addr", res_data, 16'h0001);
        @(negedge clk);
        chk("R13 valid drops", res_valid, 0);
    endtask

    initial begin
        set_regs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_regs();
        t_indirect();
        t_stack();
        t_nextword();
        t_short();
        t_order();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule